// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a time-division serial audio link. The codec on the far side drives the bit clock, and the block runs entirely on that clock. Each frame lasts 256 bit clocks. The block marks each frame with a sync pulse. It shifts one frame of outbound slot data onto the serial output and gathers one frame of inbound slot data from the serial input.

A frame holds a 16-bit tag slot followed by twelve 20-bit data slots, and every slot is sent most significant bit first. The user logic presents the outbound frame as parallel words, which are sampled once at the start of each frame. It receives the inbound frame as parallel words that change together, marked by a one-cycle completion pulse.

All outputs change on the rising edge of the clock. The serial input is sampled on the falling edge. Both directions occupy the same bit positions of the frame.

Top module: `aclk_link_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `sync`, `sdo` and `frame_done` low and clears `rx_tag` and `rx_slots` to zero. The first rising edge that samples `rst` low starts a frame by raising `sync`.
- R2: `sync` rises once every 256 clocks. It stays high for 16 consecutive cycles and is then low for 240.
- R3: The outbound words `tx_tag` and `tx_slots` are sampled only on the edge where `sync` rises. Changes to them at any other time have no effect on the frame in progress.
- R4: The outbound frame is `{tx_tag, tx_slots}`, sent most significant bit first. Data slot n (1 to 12) occupies `tx_slots[(13-n)*20-1 -: 20]`, so slot 1 starts at frame bit 16 and slot n at bit 16+20(n-1). Take E0 as the edge where `sync` rises. Frame bit i (i = 0 to 254) is driven on `sdo` at edge E(i+1), and bit 255 is driven at the next frame's E0.
- R5: `sdi` is sampled on falling edges. The sample taken after edge E(i+1) is inbound frame bit i, with bit 255 taken after the next E0. The inbound frame uses the same layout as R4 and is presented as `{rx_tag, rx_slots}`.
- R6: `rx_tag` and `rx_slots` update together at edge E1 of the frame after the one they came from. `frame_done` is high for exactly that one cycle. No pulse is produced for the frame in progress when reset is released.
- R7: Between `frame_done` pulses, `rx_tag` and `rx_slots` hold their values.
- R8: The `sdo` bit driven at E0 of the first frame after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous reset, active high |
| tx_tag | input | 16 | Outbound tag slot word |
| tx_slots | input | 240 | Outbound data slots 1..12, slot 1 in the top 20 bits |
| sdi | input | 1 | Serial data from the codec |
| sync | output | 1 | Frame sync pulse |
| sdo | output | 1 | Serial data to the codec |
| rx_tag | output | 16 | Inbound tag slot word of the last complete frame |
| rx_slots | output | 240 | Inbound data slots 1..12, slot 1 in the top 20 bits |
| frame_done | output | 1 | One-cycle pulse when the inbound words update |

## Verification
The bench acts as the codec. It follows the frame position from the sync rise, so a design with a wrong frame period or sync width shows up as a misplaced sync edge. The outbound words are overwritten with their complement a few bits into every frame. A design that loaded them anywhere other than the sync edge would put corrupted slots on the wire. Inbound patterns include a frame with only its first and last bits set, which exposes a design that samples on the wrong edge or captures one bit early or late. The bench also checks that the first partial frame after reset produces no completion pulse and that the received words hold still between pulses.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int DATA_SLOTS = 12;
    localparam int SLOTS_W    = DATA_SLOTS * SLOT_W;
    localparam int FRAME_W    = TAG_W + SLOTS_W;
    localparam int CNT_W      = $clog2(FRAME_W);
    localparam int SYNC_HI    = 16;

    typedef logic [CNT_W-1:0]   bitpos_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [SLOTS_W-1:0] slots;
    } frame_s;

    typedef struct packed {
        logic start;
        logic capture;
    } tick_s;

    // Bit offset of data slot n (1..DATA_SLOTS) within the packed slot vector.
    function automatic int slot_lsb(input int n);
        return (DATA_SLOTS - n) * SLOT_W;
    endfunction

endpackage

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer
    import aclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output logic  sync_o,
    output tick_s tick_o
);

    bitpos_t cnt_q;
    logic    started_q;
    logic    armed_q;

    // FRAME_W is a power of two, so the counter wraps on its own.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sync_o    <= 1'b0;
            started_q <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + bitpos_t'(1);
            sync_o <= (cnt_q < bitpos_t'(SYNC_HI));
            if (cnt_q == '0) begin
                started_q <= 1'b1;
                armed_q   <= started_q;
            end
        end
    end

    assign tick_o.start   = (cnt_q == '0);
    assign tick_o.capture = (cnt_q == bitpos_t'(1)) && armed_q;

endmodule

// File: rtl/aclk_tx_shifter.sv
module aclk_tx_shifter
    import aclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_i,
    output logic   sdo_o
);

    frame_t sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            sdo_o <= 1'b0;
        end else begin
            sdo_o <= sh_q[FRAME_W-1];
            if (load) begin
                sh_q <= frame_i;
            end else begin
                sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/aclk_rx_shifter.sv
module aclk_rx_shifter
    import aclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sdi_i,
    input  logic               capture,
    output logic [TAG_W-1:0]   tag_o,
    output logic [SLOTS_W-1:0] slots_o,
    output logic               done_o
);

    frame_t sh_q;
    frame_s cap;

    // Inbound bits are taken on the falling edge, half a cycle after launch.
    always_ff @(negedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
        end
    end

    assign cap = frame_s'(sh_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= capture;
            if (capture) begin
                tag_o <= cap.tag;
            end
        end
    end

    for (genvar n = 1; n <= DATA_SLOTS; n++) begin : g_slot
        logic [SLOT_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (capture) begin
                word_q <= cap.slots[slot_lsb(n) +: SLOT_W];
            end
        end
        assign slots_o[slot_lsb(n) +: SLOT_W] = word_q;
    end

endmodule

// File: rtl/aclk_link_ctrl.sv
module aclk_link_ctrl
    import aclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [TAG_W-1:0]   tx_tag,
    input  logic [SLOTS_W-1:0] tx_slots,
    input  logic               sdi,
    output logic               sync,
    output logic               sdo,
    output logic [TAG_W-1:0]   rx_tag,
    output logic [SLOTS_W-1:0] rx_slots,
    output logic               frame_done
);

    tick_s  tick;
    frame_s tx_frame;

    assign tx_frame.tag   = tx_tag;
    assign tx_frame.slots = tx_slots;

    aclk_frame_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .sync_o (sync),
        .tick_o (tick)
    );

    aclk_tx_shifter u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tick.start),
        .frame_i (frame_t'(tx_frame)),
        .sdo_o   (sdo)
    );

    aclk_rx_shifter u_rx (
        .clk     (clk),
        .rst     (rst),
        .sdi_i   (sdi),
        .capture (tick.capture),
        .tag_o   (rx_tag),
        .slots_o (rx_slots),
        .done_o  (frame_done)
    );

endmodule

// File: rtl/aclk_link_checker.sv
module aclk_link_checker
    import aclk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sync,
    input logic               sdo,
    input logic [TAG_W-1:0]   rx_tag,
    input logic [SLOTS_W-1:0] rx_slots,
    input logic               frame_done
);

    logic       sync_d;
    logic       seen_q;
    logic [8:0] gap_q;
    logic       rose_w;

    assign rose_w = sync && !sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= 1'b0;
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            sync_d <= sync;
            seen_q <= seen_q | rose_w;
            gap_q  <= rose_w ? 9'd1 : gap_q + 9'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sync && !sdo && !frame_done && rx_tag == '0 && rx_slots == '0));

    p_frame_period_r2: assert property (@(posedge clk) disable iff (rst)
        (rose_w && seen_q) |-> (gap_q == 9'd256));

    p_sync_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !rose_w) |-> (sync == (gap_q < 9'd16)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_align_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (sync && $past(sync) && !$past(sync, 2)));

    p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_done |-> ($stable(rx_tag) && $stable(rx_slots)));

endmodule

bind aclk_link_ctrl aclk_link_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync       (sync),
    .sdo        (sdo),
    .rx_tag     (rx_tag),
    .rx_slots   (rx_slots),
    .frame_done (frame_done)
);

// File: tb/aclk_link_ctrl_tb.sv
module aclk_link_ctrl_tb;
    import aclk_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [TAG_W-1:0]   tx_tag;
    logic [SLOTS_W-1:0] tx_slots;
    logic               sdi;
    logic               sync;
    logic               sdo;
    logic [TAG_W-1:0]   rx_tag;
    logic [SLOTS_W-1:0] rx_slots;
    logic               frame_done;

    always #10 clk = ~clk;

    aclk_link_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .tx_tag     (tx_tag),
        .tx_slots   (tx_slots),
        .sdi        (sdi),
        .sync       (sync),
        .sdo        (sdo),
        .rx_tag     (rx_tag),
        .rx_slots   (rx_slots),
        .frame_done (frame_done)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    frame_t tx_q[$];
    frame_t rx_q[$];
    logic   mon_en   = 1'b0;
    logic   mon_done = 1'b0;

    task automatic check(input bit ok, input string what, input frame_t act, input frame_t exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic frame_t tx_pat(input int f);
        frame_t fr;
        case (f % 4)
            0: begin
                fr[FRAME_W-1 -: TAG_W] = 16'hC35A ^ TAG_W'(f);
                for (int n = 1; n <= DATA_SLOTS; n++)
                    fr[slot_lsb(n) +: SLOT_W] = SLOT_W'(n * 32'h1F3B5 + f * 7);
            end
            1: fr = '1;
            2: fr = '0;
            default: fr = {(FRAME_W/2){2'b10}};
        endcase
        return fr;
    endfunction

    function automatic frame_t rx_pat(input int f);
        frame_t fr;
        case (f % 3)
            0: begin
                fr[FRAME_W-1 -: TAG_W] = 16'h8001 + TAG_W'(f);
                for (int n = 1; n <= DATA_SLOTS; n++)
                    fr[slot_lsb(n) +: SLOT_W] = SLOT_W'(n * 32'h2A6C1) ^ SLOT_W'(f);
            end
            1: fr = {(FRAME_W/2){2'b01}};
            default: begin
                fr = '0;
                fr[FRAME_W-1] = 1'b1;
                fr[0] = 1'b1;
            end
        endcase
        return fr;
    endfunction

    // Driver: applies an outbound frame and, when it is meant to be sent, queues it.
    task automatic drive_tx(input frame_t fr, input bit record);
        tx_tag   = fr[FRAME_W-1 -: TAG_W];
        tx_slots = fr[SLOTS_W-1:0];
        if (record) tx_q.push_back(fr);
    endtask

    task automatic cmp_frame(input string req, input frame_t act, input frame_t exp);
        check(act[FRAME_W-1 -: TAG_W] == exp[FRAME_W-1 -: TAG_W],
              $sformatf("%s tag slot", req),
              frame_t'(act[FRAME_W-1 -: TAG_W]), frame_t'(exp[FRAME_W-1 -: TAG_W]));
        for (int n = 1; n <= DATA_SLOTS; n++)
            check(act[slot_lsb(n) +: SLOT_W] == exp[slot_lsb(n) +: SLOT_W],
                  $sformatf("%s data slot %0d", req, n),
                  frame_t'(act[slot_lsb(n) +: SLOT_W]), frame_t'(exp[slot_lsb(n) +: SLOT_W]));
    endtask

    // Monitor and codec model: tracks the frame position from the sync rise.
    initial begin : monitor
        int     pos   = 0;
        int     fidx  = -1;
        logic   prev  = 1'b0;
        bit     stray = 1'b0;
        frame_t got   = '0;
        frame_t cur   = '0;
        frame_t held  = '0;
        frame_t exp;
        wait (mon_en);
        while (!mon_done) begin
            @(posedge clk);
            #1;
            if (sync && !prev) begin
                if (fidx >= 0)
                    check(pos == 255, "R2 frame length", frame_t'(pos + 1), frame_t'(256));
                pos = 0;
                fidx++;
            end else begin
                pos++;
            end
            prev = sync;
            if (frame_done && pos != 1) stray = 1'b1;

            if (pos == 0) begin
                if (fidx == 0) begin
                    check(sdo == 1'b0, "R8 first sdo bit", frame_t'(sdo), '0);
                end else begin
                    got[0] = sdo;
                    exp = tx_q.pop_front();
                    cmp_frame("R4 (R3 latch)", got, exp);
                end
                sdi = (fidx == 0) ? 1'b0 : cur[0];
            end else begin
                got[FRAME_W - pos] = sdo;
                if (pos == 1) begin
                    check(frame_done == (fidx >= 1), "R6 done timing",
                          frame_t'(frame_done), frame_t'(fidx >= 1));
                    if (fidx >= 1) begin
                        exp  = rx_q.pop_front();
                        held = {rx_tag, rx_slots};
                        cmp_frame("R5", held, exp);
                    end
                    cur = rx_pat(fidx);
                    rx_q.push_back(cur);
                end
                sdi = cur[FRAME_W - pos];
            end

            if (pos == 3) drive_tx(~tx_pat(fidx), 1'b0);
            if (pos == 128) drive_tx(tx_pat(fidx + 1), 1'b1);
            if (pos == 15) check(sync == 1'b1, "R2 sync high", frame_t'(sync), frame_t'(1));
            if (pos == 16) check(sync == 1'b0, "R2 sync low", frame_t'(sync), '0);
            if (pos == 200 && fidx >= 1)
                check({rx_tag, rx_slots} == held, "R7 rx hold", {rx_tag, rx_slots}, held);
            if (fidx == 5 && pos == 2) begin
                check(!stray, "R6 no stray done", frame_t'(stray), '0);
                mon_done = 1'b1;
            end
        end
    end

    initial begin : main
        rst = 1'b1;
        sdi = 1'b0;
        drive_tx(tx_pat(0), 1'b1);
        repeat (3) @(posedge clk);
        #1;
        check(!sync && !sdo && !frame_done, "R1 reset outputs",
              frame_t'({sync, sdo, frame_done}), '0);
        check({rx_tag, rx_slots} == '0, "R1 reset rx", {rx_tag, rx_slots}, '0);
        mon_en = 1'b1;
        rst = 1'b0;
        wait (mon_done);

        @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(!sync && !sdo && !frame_done, "R1 mid-run reset outputs",
              frame_t'({sync, sdo, frame_done}), '0);
        check({rx_tag, rx_slots} == '0, "R1 mid-run reset rx", {rx_tag, rx_slots}, '0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(sync == 1'b1, "R1 sync on first edge", frame_t'(sync), frame_t'(1));
        check(sdo == 1'b0, "R8 sdo after reset", frame_t'(sdo), '0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual no completion, expected run to finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule